// File: doc/BRIEF.md
# Tick Compare Timer with Disable Flag

This block holds two compare channels that watch one free-running tick count. Each channel has a register one bit wider than the count. The top bit is a disable flag. The remaining bits hold a target count. The first channel serves the system tick, and its match sets bit 16 of a soft-interrupt set vector. The second channel serves the hypervisor tick, and its match raises a one-cycle set strobe for the hypervisor interrupt-pending flag. The counter itself and the interrupt registers that take these strobes sit outside the block.

A write stores the full value and can arm the channel. It arms only when the disable flag is clear and the target lies strictly ahead of the count seen in the write cycle. A target at or behind the current count is stored but never fires. An armed channel raises a single-cycle pulse when the count equals the target, then disarms. Only a new write can arm it again. A later write always replaces the earlier target. Setting the disable flag cancels anything armed.

Top module: `tick_compare_unit`

## Requirements
- R1: After reset, both registers read back with the disable flag (top bit) set and a target of zero, and no match strobe is active.
- R2: The cycle after a write to a channel, that channel's read port returns the full written value, including the disable flag.
- R3: A write arms its channel only when the disable flag is clear and the target (low TICK_W bits) is strictly greater than the tick count in the write cycle. A target equal to or below that count never produces a match.
- R4: An armed channel whose target equals the tick count in some cycle produces its strobe in the following cycle, for exactly one cycle.
- R5: A write with the disable flag set cancels any armed target, and no strobe follows from it.
- R6: A second write replaces the earlier target. Only the newest target can fire.
- R7: After firing, a channel stays quiet even if the tick count equals its target again, until a new write arms it.
- R8: A system-channel match drives soft_int_set with only bit SOFT_BIT (16 by default) set. A hypervisor-channel match drives hyp_pend_set high. Neither channel affects the other's output.
- R9: When a write lands in the same cycle as a match of the old target, the write takes effect and the old target does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_now | input | TICK_W | Current free-running tick count |
| wr_en | input | 2 | Write strobe per channel: bit 0 system, bit 1 hypervisor |
| wr_data | input | TICK_W+1 | Written value: top bit disable flag, low bits target |
| rd_sys | output | TICK_W+1 | Stored system-channel register |
| rd_hyp | output | TICK_W+1 | Stored hypervisor-channel register |
| soft_int_set | output | SOFT_W | One-cycle set vector for the soft-interrupt register |
| hyp_pend_set | output | 1 | One-cycle set strobe for the hypervisor interrupt-pending flag |

## Verification
The assertions assume that the tick count only changes between clock edges, and that a target ahead of the count is reached without the count wrapping. Only then does the single-pulse check on a real match stay meaningful. The stimulus uses a 6-bit count. Start points and target offsets are chosen so that every window finishes below the wrap point. The count is stepped by one per cycle, except in the deliberate replay of an already-fired target, where it is held back.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
    localparam int unsigned TICK_W_DEF   = 63;
    localparam int unsigned SOFT_W_DEF   = 17;
    localparam int unsigned SOFT_BIT_DEF = 16;
    localparam int unsigned NUM_CH       = 2;

    typedef enum logic {
        CH_SYS = 1'b0,
        CH_HYP = 1'b1
    } chan_e;
endpackage

// File: rtl/tcmp_chan.sv
module tcmp_chan #(
    parameter int unsigned TICK_W = tcmp_pkg::TICK_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] tick_now,
    input  logic              wr_en,
    input  logic [TICK_W:0]   wr_data,
    output logic [TICK_W:0]   rd_data,
    output logic              armed,
    output logic              fire
);
    localparam int unsigned REG_W   = TICK_W + 1;
    localparam int unsigned DIS_BIT = TICK_W;

    typedef struct packed {
        logic [REG_W-1:0] cmp;
        logic             armed;
        logic             fire;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (wr_en) begin
            // a new value always wins over a match of the old one
            st_d.cmp   = wr_data;
            st_d.armed = !wr_data[DIS_BIT] && (wr_data[TICK_W-1:0] > tick_now);
        end else if (st_q.armed && !st_q.cmp[DIS_BIT]
                     && (st_q.cmp[TICK_W-1:0] == tick_now)) begin
            st_d.fire  = 1'b1;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cmp   <= REG_W'(1) << DIS_BIT;
            st_q.armed <= 1'b0;
            st_q.fire  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.cmp;
    assign armed   = st_q.armed;
    assign fire    = st_q.fire;

    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data)));

    p_past_target_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[TICK_W-1:0] <= tick_now)) |=> !armed);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    p_fire_from_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ($past(armed) && !$past(wr_en)));

    p_disable_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DIS_BIT] |-> !armed);

    p_disarm_after_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !armed);
endmodule

// File: rtl/tcmp_route.sv
module tcmp_route #(
    parameter int unsigned SOFT_W   = tcmp_pkg::SOFT_W_DEF,
    parameter int unsigned SOFT_BIT = tcmp_pkg::SOFT_BIT_DEF,
    parameter int unsigned NUM_CH   = tcmp_pkg::NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] fire,
    output logic [SOFT_W-1:0] soft_int_set,
    output logic              hyp_pend_set
);
    localparam logic [SOFT_W-1:0] SOFT_MASK = SOFT_W'(1) << SOFT_BIT;

    always_comb begin
        soft_int_set = fire[int'(tcmp_pkg::CH_SYS)] ? SOFT_MASK : '0;
        hyp_pend_set = fire[int'(tcmp_pkg::CH_HYP)];
    end

    p_soft_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_int_set != '0) |-> ($countones(soft_int_set) == 1 && soft_int_set[SOFT_BIT]));
endmodule

// File: rtl/tick_compare_unit.sv
module tick_compare_unit #(
    parameter int unsigned TICK_W   = tcmp_pkg::TICK_W_DEF,
    parameter int unsigned SOFT_W   = tcmp_pkg::SOFT_W_DEF,
    parameter int unsigned SOFT_BIT = tcmp_pkg::SOFT_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] tick_now,
    input  logic [1:0]        wr_en,
    input  logic [TICK_W:0]   wr_data,
    output logic [TICK_W:0]   rd_sys,
    output logic [TICK_W:0]   rd_hyp,
    output logic [SOFT_W-1:0] soft_int_set,
    output logic              hyp_pend_set
);
    localparam int unsigned NUM_CH = tcmp_pkg::NUM_CH;

    logic [TICK_W:0]   rd_vec [NUM_CH];
    logic [NUM_CH-1:0] armed_vec;
    logic [NUM_CH-1:0] fire_vec;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        tcmp_chan #(.TICK_W(TICK_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_now (tick_now),
            .wr_en    (wr_en[g]),
            .wr_data  (wr_data),
            .rd_data  (rd_vec[g]),
            .armed    (armed_vec[g]),
            .fire     (fire_vec[g])
        );
    end

    tcmp_route #(.SOFT_W(SOFT_W), .SOFT_BIT(SOFT_BIT), .NUM_CH(NUM_CH)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (fire_vec),
        .soft_int_set (soft_int_set),
        .hyp_pend_set (hyp_pend_set)
    );

    assign rd_sys = rd_vec[int'(tcmp_pkg::CH_SYS)];
    assign rd_hyp = rd_vec[int'(tcmp_pkg::CH_HYP)];

    p_channels_independent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 2'b01) |=> $stable(rd_hyp));
endmodule

// File: tb/sim_tick_compare_unit.sv
module sim_tick_compare_unit;
    localparam int TW = 6;
    localparam int SW = 17;
    localparam int SB = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tick_now = '0;
    logic [1:0]    wr_en = '0;
    logic [TW:0]   wr_data = '0;
    logic [TW:0]   rd_sys, rd_hyp;
    logic [SW-1:0] soft_int_set;
    logic          hyp_pend_set;

    int errs = 0;
    int total = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_compare_unit #(.TICK_W(TW), .SOFT_W(SW), .SOFT_BIT(SB)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_now(tick_now), .wr_en(wr_en),
        .wr_data(wr_data), .rd_sys(rd_sys), .rd_hyp(rd_hyp),
        .soft_int_set(soft_int_set), .hyp_pend_set(hyp_pend_set)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Wait to the falling edge, check the strobes from the last edge, then drive.
    // exp_ch: -1 none, 0 system, 1 hypervisor
    task automatic cyc(input int t, input logic [1:0] we, input logic [TW:0] d,
                       input int exp_ch, input string req);
        logic [SW-1:0] exp_soft;
        @(negedge clk);
        exp_soft = (exp_ch == 0) ? (SW'(1) << SB) : '0;
        chk(soft_int_set == exp_soft, req, 32'(soft_int_set), 32'(exp_soft));
        chk(hyp_pend_set == (exp_ch == 1), req, 32'(hyp_pend_set), 32'(exp_ch == 1));
        tick_now = TW'(t);
        wr_en    = we;
        wr_data  = d;
    endtask

    // R3/R4/R5/R8 sweep: write at tick t0 with offset dlt, step tick by one
    task automatic sweep_case(input int ch, input int t0, input int dlt, input bit dis);
        logic [TW:0] val;
        int ex;
        val = {dis, TW'(t0 + dlt)};
        cyc(t0, 2'(1 << ch), val, -1, "R4 idle before write");
        for (int k = 1; k <= 9; k++) begin
            ex = (!dis && dlt >= 1 && k == dlt + 1) ? ch : -1;
            cyc(t0 + k, 2'b00, '0, ex, dis ? "R5 disabled" : (dlt < 1 ? "R3 past target" : "R4 match"));
            if (k == 1) begin
                if (ch == 0) chk(rd_sys == val, "R2 readback sys", 32'(rd_sys), 32'(val));
                else         chk(rd_hyp == val, "R2 readback hyp", 32'(rd_hyp), 32'(val));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_sys == {1'b1, TW'(0)}, "R1 sys reset", 32'(rd_sys), 32'({1'b1, TW'(0)}));
        chk(rd_hyp == {1'b1, TW'(0)}, "R1 hyp reset", 32'(rd_hyp), 32'({1'b1, TW'(0)}));
        chk(soft_int_set == '0 && !hyp_pend_set, "R1 no strobe", 32'(soft_int_set), 0);

        for (int ch = 0; ch < 2; ch++)
            for (int t0 = 3; t0 <= 50; t0 += 7)
                for (int dlt = -3; dlt <= 6; dlt++)
                    for (int dis = 0; dis < 2; dis++)
                        sweep_case(ch, t0, dlt, dis[0]);

        // R6: target 14 replaced by 17 one cycle later; fires only after tick 17
        cyc(10, 2'b01, {1'b0, TW'(14)}, -1, "R6 setup");
        cyc(11, 2'b01, {1'b0, TW'(17)}, -1, "R6 setup");
        for (int j = 2; j <= 10; j++)
            cyc(10 + j, 2'b00, '0, (10 + j - 1 == 17) ? 0 : -1, "R6 replace");

        // R5: armed target cancelled by a disabled write of the same target
        cyc(10, 2'b10, {1'b0, TW'(14)}, -1, "R5 setup");
        cyc(11, 2'b10, {1'b1, TW'(14)}, -1, "R5 setup");
        for (int j = 2; j <= 8; j++)
            cyc(10 + j, 2'b00, '0, -1, "R5 cancel");

        // R9: write lands in the cycle tick equals the old target 13; new target 16
        cyc(10, 2'b01, {1'b0, TW'(13)}, -1, "R9 setup");
        cyc(11, 2'b00, '0, -1, "R9 setup");
        cyc(12, 2'b00, '0, -1, "R9 setup");
        cyc(13, 2'b01, {1'b0, TW'(16)}, -1, "R9 setup");
        for (int j = 4; j <= 9; j++)
            cyc(10 + j, 2'b00, '0, (10 + j - 1 == 16) ? 0 : -1, "R9 write wins");

        // R7: after firing at 20, replaying tick 20 gives nothing
        cyc(19, 2'b10, {1'b0, TW'(20)}, -1, "R7 setup");
        cyc(20, 2'b00, '0, -1, "R7 setup");
        cyc(20, 2'b00, '0, 1, "R7 first fire");
        for (int j = 0; j < 4; j++)
            cyc(20, 2'b00, '0, -1, "R7 no refire");

        // R8: both channels armed on different targets, each to its own output
        cyc(30, 2'b01, {1'b0, TW'(32)}, -1, "R8 setup");
        cyc(31, 2'b10, {1'b0, TW'(33)}, -1, "R8 setup");
        cyc(32, 2'b00, '0, -1, "R8 setup");
        cyc(33, 2'b00, '0, 0, "R8 sys only");
        cyc(34, 2'b00, '0, 1, "R8 hyp only");
        cyc(35, 2'b00, '0, -1, "R8 quiet");
        chk(rd_sys == {1'b0, TW'(32)}, "R8 sys kept", 32'(rd_sys), 32'({1'b0, TW'(32)}));

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errs++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end
endmodule